// File: doc/BRIEF.md
# Strap and Software Configuration Register Bank

This block is the byte-addressed register file that sits behind a clock generator's serial slave. It holds the frequency-select code, spread enable and spread type, per-output enable and stop-enable bits, a reference-output enable, the PLL feedback (N) and reference (M) divider fields, and fixed identification bytes. The serial slave drives a simple one-cycle write strobe with an address and a data byte, and reads through a combinational data path.

The frequency-select pins and the spread pin are captured into writable control bits on the first clock after reset is released. A software-select bit picks the source of the effective settings. While it is clear, the effective frequency code and spread enable follow the live pins through a synchronizer. While it is set, they follow the register bits. A separate read-only byte always shows the synchronized pin states. The divider fields reach the PLL only when a divider-programming enable is set. Otherwise the PLL sees fixed default dividers.

Top module: `cfg_bank`

## Requirements
- R1: During and after reset, before any write, byte 1 reads 0xFF, byte 2 reads 0x00 and byte 9 reads 0x20. The software-select, stop-drive-mode and spread-type bits of byte 0 are 0, `out_en_o` is all ones, `stop_en_o` is zero and `ref_en_o` is 1.
- R2: On the first clock after reset is released, byte 0 bits 7:4 load from `strap_fs_i[3:0]` and bit 3 loads from `strap_spread_i`. Later pin changes do not alter these bits.
- R3: A write to byte 0 updates bits 7:3 only when bit 2 (software select) was already 1 before that write. Bits 2, 1 and 0 accept every write.
- R4: With byte 0 bit 2 at 0, `eff_fs_o` and `eff_spread_en_o` equal the pin values sampled two clocks earlier. With bit 2 at 1, they equal byte 0 bits 7:4 and bit 3.
- R5: Byte 3 reads {fs3, fs2, fs1, fs0, spread} of the synchronized pins in bits 7:3, with bits 2:0 at 0, in either control mode.
- R6: Byte 4 always reads 0x01 and byte 5 always reads 0x43. Writes to them have no effect.
- R7: Reserved bits read fixed values and ignore writes. In byte 1, bits 7, 4, 3 and 0 read 1. In byte 2 the same bits read 0. In byte 9, bits 6 and 4:0 read 0. Unmapped addresses read 0x00.
- R8: The N divider is {byte 10 bit 6, byte 10 bit 7, byte 11 bits 7:0} (N[9], N[8], N[7:0]). The M divider is byte 10 bits 5:0.
- R9: `pll_n_o` and `pll_m_o` carry the register N and M only while byte 9 bit 7 is 1. Otherwise they carry the parameters DEF_N (default 92) and DEF_M (default 0).
- R10: Byte 1 bits 6, 5, 2, 1 drive `out_en_o[3..0]`, and byte 2 bits at the same positions drive `stop_en_o[3..0]`. Byte 9 bit 5 drives `ref_en_o`, byte 0 bit 1 drives `stop_hiz_o` and byte 0 bit 0 drives `spread_center_o` (1 = center spread).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address for read and write |
| wr_en_i | input | 1 | Write strobe, one byte per cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data at `addr_i` |
| strap_fs_i | input | 4 | Frequency-select strap pins |
| strap_spread_i | input | 1 | Spread-enable strap pin |
| eff_fs_o | output | 4 | Effective frequency-select code |
| eff_spread_en_o | output | 1 | Effective spread enable |
| spread_center_o | output | 1 | Spread type, 1 = center, 0 = down |
| stop_hiz_o | output | 1 | Stopped-output drive mode, 1 = high impedance |
| out_en_o | output | 4 | Per-output enables |
| stop_en_o | output | 4 | Per-output stop enables |
| ref_en_o | output | 1 | Reference output enable |
| pll_n_o | output | 10 | Effective N divider |
| pll_m_o | output | 6 | Effective M divider |

## Verification
The assertions assume the strap pins are steady across the clock edge that ends the first cycle after reset, so the latched value is well defined. They also assume that any pin-tracking relation is checked only once the two-stage synchronizer has seen at least two edges since reset. The bench changes pins only on falling clock edges, holds them for at least three cycles before it checks the effective outputs or the readback byte, and keeps the straps constant through reset release. Host writes come one at a time as one-cycle strobes, so each register value checked follows a single known write.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_OUT = 4;
  localparam int FS_W    = 4;
  localparam int N_W     = 10;
  localparam int M_W     = 6;
  localparam int PIN_W   = FS_W + 1;

  localparam int A_CTRL  = 0;
  localparam int A_OEN   = 1;
  localparam int A_STOP  = 2;
  localparam int A_PINS  = 3;
  localparam int A_VREV  = 4;
  localparam int A_DEVID = 5;
  localparam int A_DIVEN = 9;
  localparam int A_DIVHI = 10;
  localparam int A_DIVLO = 11;

  localparam logic [BYTE_W-1:0] VREV_VAL  = 8'h01;
  localparam logic [BYTE_W-1:0] DEVID_VAL = 8'h43;
  localparam logic [BYTE_W-1:0] OEN_RSV   = 8'h99;

  // bit position of output i inside bytes 1 and 2
  localparam int OUT_POS [NUM_OUT] = '{1, 2, 5, 6};

  typedef struct packed {
    logic [FS_W-1:0] fs;
    logic            spread_en;
    logic            sw_sel;
    logic            stop_hiz;
    logic            spread_center;
  } ctrl_t;
endpackage

// File: rtl/cfg_strap_sync.sv
module cfg_strap_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_bank_pkg::*;
#(
  parameter int                ADDR_W = 4,
  parameter logic [N_W-1:0]    DEF_N  = 10'd92,
  parameter logic [M_W-1:0]    DEF_M  = 6'd0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic [PIN_W-1:0]    strap_raw_i,
  input  logic [PIN_W-1:0]    pins_sync_i,
  output ctrl_t               ctrl_o,
  output logic [NUM_OUT-1:0]  out_en_o,
  output logic [NUM_OUT-1:0]  stop_en_o,
  output logic                ref_en_o,
  output logic                mn_en_o,
  output logic [N_W-1:0]      n_o,
  output logic [M_W-1:0]      m_o,
  output logic [BYTE_W-1:0]   rdata_o
);
  ctrl_t               ctrl_q, wr_ctrl;
  logic                strap_done_q;
  logic [NUM_OUT-1:0]  oen_q, stop_q;
  logic                ref_en_q, mn_en_q;
  logic [N_W-1:0]      n_q;
  logic [M_W-1:0]      m_q;
  logic [BYTE_W-1:0]   oen_byte, stop_byte;

  assign wr_ctrl = ctrl_t'(wdata_i);

  function automatic logic sel(input logic [ADDR_W-1:0] a, input int idx);
    return wr_en_i && (a == ADDR_W'(idx));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q       <= '0;
      strap_done_q <= 1'b0;
      oen_q        <= '1;
      stop_q       <= '0;
      ref_en_q     <= 1'b1;
      mn_en_q      <= 1'b0;
      n_q          <= DEF_N;
      m_q          <= DEF_M;
    end else begin
      if (!strap_done_q) begin
        // one-shot strap capture has priority over host writes
        ctrl_q.fs        <= strap_raw_i[PIN_W-1:1];
        ctrl_q.spread_en <= strap_raw_i[0];
        strap_done_q     <= 1'b1;
      end else if (sel(addr_i, A_CTRL)) begin
        if (ctrl_q.sw_sel) begin
          ctrl_q.fs        <= wr_ctrl.fs;
          ctrl_q.spread_en <= wr_ctrl.spread_en;
        end
        ctrl_q.sw_sel        <= wr_ctrl.sw_sel;
        ctrl_q.stop_hiz      <= wr_ctrl.stop_hiz;
        ctrl_q.spread_center <= wr_ctrl.spread_center;
      end
      if (sel(addr_i, A_OEN))
        for (int i = 0; i < NUM_OUT; i++) oen_q[i] <= wdata_i[OUT_POS[i]];
      if (sel(addr_i, A_STOP))
        for (int i = 0; i < NUM_OUT; i++) stop_q[i] <= wdata_i[OUT_POS[i]];
      if (sel(addr_i, A_DIVEN)) begin
        mn_en_q  <= wdata_i[7];
        ref_en_q <= wdata_i[5];
      end
      if (sel(addr_i, A_DIVHI)) begin
        n_q[8] <= wdata_i[7];
        n_q[9] <= wdata_i[6];
        m_q    <= wdata_i[M_W-1:0];
      end
      if (sel(addr_i, A_DIVLO)) n_q[7:0] <= wdata_i;
    end
  end

  always_comb begin
    oen_byte  = OEN_RSV;
    stop_byte = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      oen_byte[OUT_POS[i]]  = oen_q[i];
      stop_byte[OUT_POS[i]] = stop_q[i];
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(A_CTRL):  rdata_o = ctrl_q;
      ADDR_W'(A_OEN):   rdata_o = oen_byte;
      ADDR_W'(A_STOP):  rdata_o = stop_byte;
      ADDR_W'(A_PINS):  rdata_o = {pins_sync_i, 3'b000};
      ADDR_W'(A_VREV):  rdata_o = VREV_VAL;
      ADDR_W'(A_DEVID): rdata_o = DEVID_VAL;
      ADDR_W'(A_DIVEN): rdata_o = {mn_en_q, 1'b0, ref_en_q, 5'b00000};
      ADDR_W'(A_DIVHI): rdata_o = {n_q[8], n_q[9], m_q};
      ADDR_W'(A_DIVLO): rdata_o = n_q[7:0];
      default:          rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign out_en_o  = oen_q;
  assign stop_en_o = stop_q;
  assign ref_en_o  = ref_en_q;
  assign mn_en_o   = mn_en_q;
  assign n_o       = n_q;
  assign m_o       = m_q;
endmodule

// File: rtl/cfg_eff_sel.sv
module cfg_eff_sel
  import cfg_bank_pkg::*;
#(
  parameter logic [N_W-1:0] DEF_N = 10'd92,
  parameter logic [M_W-1:0] DEF_M = 6'd0
) (
  input  logic             sw_sel_i,
  input  logic [FS_W-1:0]  reg_fs_i,
  input  logic             reg_spread_i,
  input  logic [PIN_W-1:0] pins_sync_i,
  input  logic             mn_en_i,
  input  logic [N_W-1:0]   n_i,
  input  logic [M_W-1:0]   m_i,
  output logic [FS_W-1:0]  eff_fs_o,
  output logic             eff_spread_o,
  output logic [N_W-1:0]   pll_n_o,
  output logic [M_W-1:0]   pll_m_o
);
  always_comb begin
    if (sw_sel_i) begin
      eff_fs_o     = reg_fs_i;
      eff_spread_o = reg_spread_i;
    end else begin
      eff_fs_o     = pins_sync_i[PIN_W-1:1];
      eff_spread_o = pins_sync_i[0];
    end
    pll_n_o = mn_en_i ? n_i : DEF_N;
    pll_m_o = mn_en_i ? m_i : DEF_M;
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_bank_pkg::*;
#(
  parameter int             ADDR_W      = 4,
  parameter int             SYNC_STAGES = 2,
  parameter logic [N_W-1:0] DEF_N       = 10'd92,
  parameter logic [M_W-1:0] DEF_M       = 6'd0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [BYTE_W-1:0]   rdata_o,
  input  logic [FS_W-1:0]     strap_fs_i,
  input  logic                strap_spread_i,
  output logic [FS_W-1:0]     eff_fs_o,
  output logic                eff_spread_en_o,
  output logic                spread_center_o,
  output logic                stop_hiz_o,
  output logic [NUM_OUT-1:0]  out_en_o,
  output logic [NUM_OUT-1:0]  stop_en_o,
  output logic                ref_en_o,
  output logic [N_W-1:0]      pll_n_o,
  output logic [M_W-1:0]      pll_m_o
);
  logic [PIN_W-1:0] strap_raw, pins_sync;
  ctrl_t            ctrl;
  logic             mn_en;
  logic [N_W-1:0]   n_reg;
  logic [M_W-1:0]   m_reg;

  assign strap_raw = {strap_fs_i, strap_spread_i};

  cfg_strap_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (strap_raw),
    .q_o   (pins_sync)
  );

  cfg_regs #(.ADDR_W(ADDR_W), .DEF_N(DEF_N), .DEF_M(DEF_M)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .strap_raw_i(strap_raw),
    .pins_sync_i(pins_sync),
    .ctrl_o     (ctrl),
    .out_en_o   (out_en_o),
    .stop_en_o  (stop_en_o),
    .ref_en_o   (ref_en_o),
    .mn_en_o    (mn_en),
    .n_o        (n_reg),
    .m_o        (m_reg),
    .rdata_o    (rdata_o)
  );

  cfg_eff_sel #(.DEF_N(DEF_N), .DEF_M(DEF_M)) u_sel (
    .sw_sel_i    (ctrl.sw_sel),
    .reg_fs_i    (ctrl.fs),
    .reg_spread_i(ctrl.spread_en),
    .pins_sync_i (pins_sync),
    .mn_en_i     (mn_en),
    .n_i         (n_reg),
    .m_i         (m_reg),
    .eff_fs_o    (eff_fs_o),
    .eff_spread_o(eff_spread_en_o),
    .pll_n_o     (pll_n_o),
    .pll_m_o     (pll_m_o)
  );

  assign spread_center_o = ctrl.spread_center;
  assign stop_hiz_o      = ctrl.stop_hiz;
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk
  import cfg_bank_pkg::*;
#(
  parameter int             ADDR_W = 4,
  parameter logic [N_W-1:0] DEF_N  = 10'd92,
  parameter logic [M_W-1:0] DEF_M  = 6'd0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               wr_en_i,
  input logic [BYTE_W-1:0]  rdata_o,
  input logic [FS_W-1:0]    strap_fs_i,
  input logic               strap_spread_i,
  input logic [FS_W-1:0]    eff_fs_o,
  input logic [N_W-1:0]     pll_n_o,
  input logic [M_W-1:0]     pll_m_o,
  input logic               sw_sel,
  input logic               mn_en,
  input logic [FS_W-1:0]    fs_reg
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd1) |-> (fs_reg == $past(strap_fs_i)));

  p_hold_fs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0 && wr_en_i && addr_i == ADDR_W'(A_CTRL) && !sw_sel) |=> $stable(fs_reg));

  p_pin_track_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && !sw_sel) |-> (eff_fs_o == $past(strap_fs_i, 2)));

  p_readback_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && addr_i == ADDR_W'(A_PINS))
      |-> (rdata_o == {$past(strap_fs_i, 2), $past(strap_spread_i, 2), 3'b000}));

  p_vrev_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(A_VREV)) |-> (rdata_o == 8'h01));

  p_devid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(A_DEVID)) |-> (rdata_o == 8'h43));

  p_rsv_oen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(A_OEN)) |-> ((rdata_o & 8'h99) == 8'h99));

  p_rsv_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(A_STOP)) |-> ((rdata_o & 8'h99) == 8'h00));

  p_div_dflt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mn_en |-> (pll_n_o == DEF_N && pll_m_o == DEF_M));
endmodule

bind cfg_bank cfg_bank_chk #(.ADDR_W(ADDR_W), .DEF_N(DEF_N), .DEF_M(DEF_M)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .wr_en_i       (wr_en_i),
  .rdata_o       (rdata_o),
  .strap_fs_i    (strap_fs_i),
  .strap_spread_i(strap_spread_i),
  .eff_fs_o      (eff_fs_o),
  .pll_n_o       (pll_n_o),
  .pll_m_o       (pll_m_o),
  .sw_sel        (ctrl.sw_sel),
  .mn_en         (mn_en),
  .fs_reg        (ctrl.fs)
);

// File: tb/sim_cfg_bank.sv
`timescale 1ns/1ps
module sim_cfg_bank;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [3:0] strap_fs_i = 4'b1010;
  logic       strap_spread_i = 1'b1;
  logic [3:0] eff_fs_o;
  logic       eff_spread_en_o, spread_center_o, stop_hiz_o, ref_en_o;
  logic [3:0] out_en_o, stop_en_o;
  logic [9:0] pll_n_o;
  logic [5:0] pll_m_o;

  always #2 clk_i = ~clk_i;

  cfg_bank u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .strap_fs_i(strap_fs_i),
    .strap_spread_i(strap_spread_i), .eff_fs_o(eff_fs_o),
    .eff_spread_en_o(eff_spread_en_o), .spread_center_o(spread_center_o),
    .stop_hiz_o(stop_hiz_o), .out_en_o(out_en_o), .stop_en_o(stop_en_o),
    .ref_en_o(ref_en_o), .pll_n_o(pll_n_o), .pll_m_o(pll_m_o)
  );

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  localparam int S_RD = 0, S_FS = 1, S_SP = 2, S_N = 3, S_M = 4, S_OEN = 5,
                 S_STOP = 6, S_REF = 7, S_HIZ = 8, S_CTR = 9;

  function automatic logic [31:0] actual(int sel);
    case (sel)
      S_RD:    return 32'(rdata_o);
      S_FS:    return 32'(eff_fs_o);
      S_SP:    return 32'(eff_spread_en_o);
      S_N:     return 32'(pll_n_o);
      S_M:     return 32'(pll_m_o);
      S_OEN:   return 32'(out_en_o);
      S_STOP:  return 32'(stop_en_o);
      S_REF:   return 32'(ref_en_o);
      S_HIZ:   return 32'(stop_hiz_o);
      default: return 32'(spread_center_o);
    endcase
  endfunction

  // monitor: compares everything queued in this half cycle
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (sb_q.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = actual(it.sel);
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic rchk(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk_i);
    addr_i = a;
    sb_q.push_back('{S_RD, 32'(e), tag});
  endtask

  task automatic pchk(input int sel, input logic [31:0] e, input string tag);
    @(negedge clk_i);
    sb_q.push_back('{sel, e, tag});
  endtask

  task automatic set_pins(input logic [3:0] fs, input logic sp);
    @(negedge clk_i);
    strap_fs_i = fs; strap_spread_i = sp;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    rchk(4'd0, 8'h00, "R1 ctrl in reset");
    rchk(4'd1, 8'hFF, "R1 oen in reset");
    rchk(4'd2, 8'h00, "R1 stop in reset");
    rchk(4'd9, 8'h20, "R1 diven in reset");
    @(negedge clk_i) rst_ni = 1'b1;
    // R2 strap latch
    rchk(4'd0, 8'hA8, "R2 strap latched");
    pchk(S_OEN, 32'hF, "R1 out_en after reset");
    pchk(S_STOP, 32'h0, "R1 stop_en after reset");
    pchk(S_REF, 32'h1, "R1 ref_en after reset");
    pchk(S_N, 32'd92, "R9 default N");
    pchk(S_M, 32'd0, "R9 default M");
    // R6 ids
    rchk(4'd4, 8'h01, "R6 vendor/revision");
    rchk(4'd5, 8'h43, "R6 device id");
    wr(4'd4, 8'hFF);
    wr(4'd5, 8'h00);
    rchk(4'd4, 8'h01, "R6 vendor/revision after write");
    rchk(4'd5, 8'h43, "R6 device id after write");
    // R5 readback and R4 pin tracking
    rchk(4'd3, 8'hA8, "R5 readback initial");
    set_pins(4'b0101, 1'b0);
    rchk(4'd3, 8'h50, "R5 readback changed");
    rchk(4'd0, 8'hA8, "R2 latch unaffected by pins");
    pchk(S_FS, 32'h5, "R4 hw fs follows pins");
    pchk(S_SP, 32'h0, "R4 hw spread follows pins");
    // R3 write protection
    wr(4'd0, 8'h33);
    rchk(4'd0, 8'hAB, "R3 fs protected when sw_sel=0");
    pchk(S_HIZ, 32'h1, "R10 stop_hiz");
    pchk(S_CTR, 32'h1, "R10 spread center");
    pchk(S_FS, 32'h5, "R4 still pins");
    wr(4'd0, 8'h04);
    rchk(4'd0, 8'hAC, "R3 sw_sel set, fs unchanged");
    pchk(S_FS, 32'hA, "R4 sw fs from register");
    pchk(S_SP, 32'h1, "R4 sw spread from register");
    wr(4'd0, 8'h34);
    rchk(4'd0, 8'h34, "R3 fs written when sw_sel=1");
    pchk(S_FS, 32'h3, "R4 sw fs new value");
    pchk(S_SP, 32'h0, "R4 sw spread new value");
    set_pins(4'b1111, 1'b1);
    pchk(S_FS, 32'h3, "R4 sw mode ignores pins");
    rchk(4'd3, 8'hF8, "R5 readback in sw mode");
    wr(4'd0, 8'h00);
    rchk(4'd0, 8'h00, "R3 clear with sw_sel previously 1");
    pchk(S_FS, 32'hF, "R4 back to pins");
    pchk(S_SP, 32'h1, "R4 back to pin spread");
    // R7 / R10 reserved and enables
    wr(4'd1, 8'h00);
    rchk(4'd1, 8'h99, "R7 oen reserved ones");
    pchk(S_OEN, 32'h0, "R10 out_en cleared");
    wr(4'd1, 8'h40);
    rchk(4'd1, 8'hD9, "R7 oen single bit");
    pchk(S_OEN, 32'h8, "R10 out_en bit 6 -> output 3");
    wr(4'd2, 8'hFF);
    rchk(4'd2, 8'h66, "R7 stop reserved zeros");
    pchk(S_STOP, 32'hF, "R10 stop_en set");
    wr(4'd2, 8'h02);
    pchk(S_STOP, 32'h1, "R10 stop bit 1 -> output 0");
    wr(4'd7, 8'hFF);
    rchk(4'd7, 8'h00, "R7 unmapped reads zero");
    // R8 / R9 dividers
    wr(4'd10, 8'h85);
    wr(4'd11, 8'h3C);
    pchk(S_N, 32'd92, "R9 N default while disabled");
    pchk(S_M, 32'd0, "R9 M default while disabled");
    rchk(4'd10, 8'h85, "R8 divhi readback");
    wr(4'd9, 8'hFF);
    rchk(4'd9, 8'hA0, "R7 diven reserved zeros");
    pchk(S_N, 32'h13C, "R8 N with bit8 set");
    pchk(S_M, 32'd5, "R8 M field");
    wr(4'd10, 8'h45);
    pchk(S_N, 32'h23C, "R8 N with bit9 set");
    wr(4'd9, 8'h00);
    pchk(S_REF, 32'h0, "R10 ref_en cleared");
    pchk(S_N, 32'd92, "R9 N default after disable");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule